// File: doc/BRIEF.md
# Partitioned Control-Mask Lookup Store

This block holds the control masks used to cancel unknown values out of compacted test signatures. The scan response of every test vector is divided into a fixed number of slice partitions, and each partition is compacted into its own signature. For each partition, off-line clustering produces a small number of merged groups. Each group has one mask word that selects which signature bits are combined.

All mask words are written into an on-chip array while the block is in load mode, before testing begins. In run mode the tester no longer sends masks. For each signature it sends only a short group number on a strobe. An internal partition counter, advanced by every run-mode strobe, supplies the upper address bits and the group number supplies the lower ones. The selected mask appears one cycle later for the readout logic, together with the partition it belongs to.

A group number beyond the configured number of groups per partition is rejected with an error pulse and its mask is not fetched. The slot is still counted, so the partitions of later signatures stay aligned.

Top module: `xmask_lookup`

## Requirements
- R1: After reset, mask_valid_o and idx_err_o are 0, mask_o is all zeros and part_o is 0.
- R2: While load_mode_i is 1, a cycle with wr_en_i at 1 stores wr_data_i at wr_addr_i. The address is the partition number in the upper PART_W bits concatenated with the group slot in the lower IDX_W bits. A write with load_mode_i at 0 changes no stored word.
- R3: A run-mode strobe (sel_valid_i at 1, load_mode_i at 0) with an in-range group reads the word at address {partition counter, sel_idx_i}.
- R4: One cycle after an in-range run-mode strobe, mask_valid_o is 1 for exactly one cycle. In that cycle mask_o carries the addressed word and part_o the partition used.
- R5: A group number of SETS_PER_PART or more is out of range. One cycle after such a strobe, idx_err_o is 1 and mask_valid_o is 0. mask_o keeps its previous value and part_o shows the partition that was consumed.
- R6: The partition counter advances by one on every run-mode strobe, whether the group is in range or not. It wraps from NUM_PARTS-1 to 0.
- R7: While load_mode_i is 1, strobes produce neither mask_valid_o nor idx_err_o, and the partition counter is held at 0. The first run-mode strobe after load mode therefore uses partition 0.
- R8: mask_o changes only in the cycle after an in-range run-mode strobe. mask_valid_o and idx_err_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_mode_i | input | 1 | 1 = preload mode, 0 = run mode |
| wr_en_i | input | 1 | Preload write enable |
| wr_addr_i | input | ADDR_W | Preload address {partition, slot} |
| wr_data_i | input | MASK_W | Preload mask word |
| sel_valid_i | input | 1 | Group number strobe, one per signature |
| sel_idx_i | input | IDX_W | Merged group number for this signature |
| mask_valid_o | output | 1 | Fetched mask is valid this cycle |
| mask_o | output | MASK_W | Fetched mask word |
| part_o | output | PART_W | Partition of the latest result |
| idx_err_o | output | 1 | Out-of-range group number was given |

## Verification
Every strobe has exactly one result, and that result is due one clock edge after the edge that samples the strobe. The result is mask_valid_o or idx_err_o together with mask_o and part_o. The bench therefore drives each strobe just after a falling edge and compares the outputs at the following falling edge. That falling edge is also where it drives the next strobe, so back-to-back strobes are checked without any skew. Checks taken in quiet cycles after a strobe confirm that the valid and error pulses last one cycle and that mask_o holds. The expected partition comes from a counter kept in the bench that wraps at NUM_PARTS. The expected mask is the arithmetic pattern the bench wrote at address partition*SET_SLOTS+group.

// File: rtl/xmask_pkg.sv
package xmask_pkg;

   // Smallest power of two not below n (n >= 1).
   function automatic int unsigned pow2_ceil(input int unsigned n);
      int unsigned r;
      r = 1;
      while (r < n) r = r << 1;
      return r;
   endfunction

   // Address of a mask word: partition region times region size plus slot.
   function automatic int unsigned region_addr(input int unsigned part,
                                               input int unsigned slot,
                                               input int unsigned slots);
      return part * slots + slot;
   endfunction

endpackage

// File: rtl/xmask_part_ctr.sv
module xmask_part_ctr #(
   parameter int unsigned NUM_PARTS = 4,
   localparam int unsigned PART_W   = $clog2(NUM_PARTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              step_i,
   output logic [PART_W-1:0] part_o
);

   logic [PART_W-1:0] cnt_q;
   logic [PART_W-1:0] cnt_inc;

   generate
      if ((1 << PART_W) == NUM_PARTS) begin : g_natural_wrap
         assign cnt_inc = cnt_q + 1'b1;
      end else begin : g_compare_wrap
         localparam logic [PART_W-1:0] LAST = PART_W'(NUM_PARTS - 1);
         assign cnt_inc = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_inc;
      end
   end

   assign part_o = cnt_q;

endmodule

// File: rtl/xmask_idx_check.sv
module xmask_idx_check #(
   parameter int unsigned SETS_PER_PART = 3,
   parameter int unsigned IDX_W         = 2
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic             in_range_o
);

   generate
      if ((1 << IDX_W) == SETS_PER_PART) begin : g_full_region
         // Every encodable slot is a configured group.
         assign in_range_o = 1'b1;
      end else begin : g_partial_region
         localparam logic [IDX_W-1:0] LIMIT = IDX_W'(SETS_PER_PART);
         assign in_range_o = (idx_i < LIMIT);
      end
   endgenerate

endmodule

// File: rtl/xmask_store.sv
module xmask_store #(
   parameter int unsigned MASK_W = 16,
   parameter int unsigned ADDR_W = 4,
   localparam int unsigned DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [MASK_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [MASK_W-1:0] rdata_o
);

   logic [MASK_W-1:0] mem_q [DEPTH];
   logic [MASK_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (we_i) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (re_i) begin
         rd_q <= mem_q[raddr_i];
      end
   end

   assign rdata_o = rd_q;

endmodule

// File: rtl/xmask_lookup.sv
module xmask_lookup
   import xmask_pkg::*;
#(
   parameter int unsigned MASK_W        = 16,
   parameter int unsigned NUM_PARTS     = 4,
   parameter int unsigned SETS_PER_PART = 3,
   localparam int unsigned SET_SLOTS    = pow2_ceil(SETS_PER_PART),
   localparam int unsigned IDX_W        = $clog2(SET_SLOTS),
   localparam int unsigned PART_W       = $clog2(NUM_PARTS),
   localparam int unsigned ADDR_W       = PART_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_mode_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [MASK_W-1:0] wr_data_i,
   input  logic              sel_valid_i,
   input  logic [IDX_W-1:0]  sel_idx_i,
   output logic              mask_valid_o,
   output logic [MASK_W-1:0] mask_o,
   output logic [PART_W-1:0] part_o,
   output logic              idx_err_o
);

   generate
      if (MASK_W < 1) begin : g_bad_mask_w
         $error("xmask_lookup: MASK_W must be at least 1");
      end
      if (NUM_PARTS < 2) begin : g_bad_parts
         $error("xmask_lookup: NUM_PARTS must be at least 2");
      end
      if (SETS_PER_PART < 2) begin : g_bad_sets
         $error("xmask_lookup: SETS_PER_PART must be at least 2");
      end
      if (ADDR_W > 12) begin : g_bad_depth
         $error("xmask_lookup: mask array too deep for a flop store");
      end
   endgenerate

   logic              run_strobe;
   logic              idx_ok;
   logic              fetch;
   logic [PART_W-1:0] cur_part;
   logic [ADDR_W-1:0] rd_addr;
   logic              valid_q;
   logic              err_q;
   logic [PART_W-1:0] part_q;

   assign run_strobe = sel_valid_i && !load_mode_i;
   assign fetch      = run_strobe && idx_ok;
   assign rd_addr    = {cur_part, sel_idx_i};

   xmask_part_ctr #(
      .NUM_PARTS(NUM_PARTS)
   ) part_ctr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(load_mode_i),
      .step_i (run_strobe),
      .part_o (cur_part)
   );

   xmask_idx_check #(
      .SETS_PER_PART(SETS_PER_PART),
      .IDX_W        (IDX_W)
   ) idx_check_i (
      .idx_i     (sel_idx_i),
      .in_range_o(idx_ok)
   );

   xmask_store #(
      .MASK_W(MASK_W),
      .ADDR_W(ADDR_W)
   ) store_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (load_mode_i && wr_en_i),
      .waddr_i(wr_addr_i),
      .wdata_i(wr_data_i),
      .re_i   (fetch),
      .raddr_i(rd_addr),
      .rdata_o(mask_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         part_q  <= '0;
      end else begin
         valid_q <= fetch;
         err_q   <= run_strobe && !idx_ok;
         if (run_strobe) begin
            part_q <= cur_part;
         end
      end
   end

   assign mask_valid_o = valid_q;
   assign idx_err_o    = err_q;
   assign part_o       = part_q;

endmodule

// File: rtl/xmask_lookup_chk.sv
module xmask_lookup_chk #(
   parameter int unsigned MASK_W        = 16,
   parameter int unsigned NUM_PARTS     = 4,
   parameter int unsigned SETS_PER_PART = 3,
   parameter int unsigned IDX_W         = 2,
   parameter int unsigned PART_W        = 2,
   parameter int unsigned ADDR_W        = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_mode_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic [MASK_W-1:0] wr_data_i,
   input logic              sel_valid_i,
   input logic [IDX_W-1:0]  sel_idx_i,
   input logic              mask_valid_o,
   input logic [MASK_W-1:0] mask_o,
   input logic [PART_W-1:0] part_o,
   input logic              idx_err_o
);

   function automatic logic [PART_W-1:0] next_part(input logic [PART_W-1:0] p);
      return (32'(p) == NUM_PARTS - 1) ? '0 : p + 1'b1;
   endfunction

   logic run_stb;
   logic in_rng;
   assign run_stb = sel_valid_i && !load_mode_i;
   assign in_rng  = 32'(sel_idx_i) < SETS_PER_PART;

   // R4: an in-range run-mode strobe yields a valid mask next cycle
   a_r4_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
      (run_stb && in_rng) |=> (mask_valid_o && !idx_err_o));

   // R5: an out-of-range group gives an error and no mask
   a_r5_err_next: assert property (@(posedge clk) disable iff (!rst_n)
      (run_stb && !in_rng) |=> (idx_err_o && !mask_valid_o && $stable(mask_o)));

   // R7: load mode blocks all results
   a_r7_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_stb) |=> (!mask_valid_o && !idx_err_o));

   // R6: back-to-back strobes consume consecutive partitions
   a_r6_part_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run_stb && $past(run_stb)) |-> ##1 (part_o == next_part($past(part_o))));

   // R8: the mask only moves after a fetch
   a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(run_stb && in_rng) |=> $stable(mask_o));

   // R8: valid and error are exclusive
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mask_valid_o && idx_err_o));

   // R6: the reported partition never leaves the configured range
   a_r6_part_range: assert property (@(posedge clk) disable iff (!rst_n)
      32'(part_o) < NUM_PARTS);

endmodule

bind xmask_lookup xmask_lookup_chk #(
   .MASK_W       (MASK_W),
   .NUM_PARTS    (NUM_PARTS),
   .SETS_PER_PART(SETS_PER_PART),
   .IDX_W        (IDX_W),
   .PART_W       (PART_W),
   .ADDR_W       (ADDR_W)
) chk_i (.*);

// File: tb/xmask_lookup_tb_top.sv
module xmask_lookup_tb_top;

   localparam int unsigned MASK_W = 12;
   localparam int unsigned NP     = 3;
   localparam int unsigned NS     = 3;
   localparam int unsigned SLOTS  = 4;
   localparam int unsigned IDX_W  = 2;
   localparam int unsigned PART_W = 2;
   localparam int unsigned ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              load_mode_i = 1'b0;
   logic              wr_en_i = 1'b0;
   logic [ADDR_W-1:0] wr_addr_i = '0;
   logic [MASK_W-1:0] wr_data_i = '0;
   logic              sel_valid_i = 1'b0;
   logic [IDX_W-1:0]  sel_idx_i = '0;
   logic              mask_valid_o;
   logic [MASK_W-1:0] mask_o;
   logic [PART_W-1:0] part_o;
   logic              idx_err_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   int exp_part = 0;
   logic [MASK_W-1:0] exp_mask = '0;
   logic [MASK_W-1:0] shadow [16];

   always #2 clk = ~clk;

   xmask_lookup #(
      .MASK_W(MASK_W), .NUM_PARTS(NP), .SETS_PER_PART(NS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .load_mode_i(load_mode_i), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .sel_valid_i(sel_valid_i),
      .sel_idx_i(sel_idx_i), .mask_valid_o(mask_valid_o), .mask_o(mask_o),
      .part_o(part_o), .idx_err_o(idx_err_o)
   );

   function automatic logic [MASK_W-1:0] pat(input int a);
      return MASK_W'((a * 173 + 91) ^ (a << 7));
   endfunction

   task automatic check(input string req, input int got, input int exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // Compare the result of a strobe with group idx issued one cycle earlier.
   task automatic check_result(input int idx);
      if (idx < NS) begin
         exp_mask = shadow[exp_part * SLOTS + idx];
         check("R4 valid", int'(mask_valid_o), 1);
         check("R3 mask word", int'(mask_o), int'(exp_mask));
         check("R4 part", int'(part_o), exp_part);
         check("R5 no err", int'(idx_err_o), 0);
      end else begin
         check("R5 err", int'(idx_err_o), 1);
         check("R5 no valid", int'(mask_valid_o), 0);
         check("R5 mask held", int'(mask_o), int'(exp_mask));
         check("R5 part consumed", int'(part_o), exp_part);
      end
      exp_part = (exp_part == NP - 1) ? 0 : exp_part + 1;   // R6 wrap
   endtask

   task automatic write_word(input int a, input logic [MASK_W-1:0] d);
      @(negedge clk);
      wr_en_i   = 1'b1;
      wr_addr_i = ADDR_W'(a);
      wr_data_i = d;
      @(negedge clk);
      wr_en_i   = 1'b0;
   endtask

   task automatic strobe_once(input int idx);
      @(negedge clk);
      sel_valid_i = 1'b1;
      sel_idx_i   = IDX_W'(idx);
      @(negedge clk);
      sel_valid_i = 1'b0;
      check_result(idx);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
         end
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 valid", int'(mask_valid_o), 0);
      check("R1 err", int'(idx_err_o), 0);
      check("R1 mask", int'(mask_o), 0);
      check("R1 part", int'(part_o), 0);
      rst_n = 1'b1;

      // R2 preload every address
      load_mode_i = 1'b1;
      for (int a = 0; a < 16; a++) begin
         shadow[a] = pat(a);
         write_word(a, pat(a));
      end
      // R7 strobes in load mode are ignored
      @(negedge clk);
      sel_valid_i = 1'b1;
      sel_idx_i   = 2'd1;
      @(negedge clk);
      sel_valid_i = 1'b0;
      check("R7 no valid in load", int'(mask_valid_o), 0);
      check("R7 no err in load", int'(idx_err_o), 0);
      load_mode_i = 1'b0;

      // R2 writes in run mode are ignored (address 0 keeps its word)
      write_word(0, 12'hFFF);

      // R3 R4 R5 R6 back-to-back sweep over every partition/group pair
      for (int s = 0; s < 24; s++) begin
         @(negedge clk);
         if (s > 0) check_result((s - 1) % SLOTS);
         sel_valid_i = 1'b1;
         sel_idx_i   = IDX_W'(s % SLOTS);
      end
      @(negedge clk);
      sel_valid_i = 1'b0;
      check_result(23 % SLOTS);
      // R8 idle cycle: pulses end, mask holds
      @(negedge clk);
      check("R8 valid pulse ends", int'(mask_valid_o), 0);
      check("R8 err pulse ends", int'(idx_err_o), 0);
      check("R8 mask holds", int'(mask_o), int'(exp_mask));

      // gapped strobes, counter continues (R6)
      strobe_once(2);
      strobe_once(3);
      strobe_once(0);
      strobe_once(1);

      // R7 load mode mid-vector resets the partition counter; R2 rewrite
      strobe_once(0);
      @(negedge clk);
      load_mode_i = 1'b1;
      shadow[1] = 12'h3C5;
      write_word(1, 12'h3C5);
      @(negedge clk);
      load_mode_i = 1'b0;
      exp_part = 0;
      strobe_once(1);
      strobe_once(2);
      strobe_once(0);
      strobe_once(3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule